// File: doc/BRIEF.md
# Debounced Reboot Delay Controller

The block turns a slow, noisy reboot request pin into a clean pair of requests for a power sequencer. A request starts only on a low-to-high change of the pin. The pin is first passed through a synchroniser. It must then stay high for a 100 ms debounce window. After that, the block waits a programmable first delay, issues a one-cycle power-off request, waits a programmable second delay, and issues a one-cycle power-on request.

Each delay is chosen by a 2-bit code: 00 gives 100 ms, 01 gives 500 ms, 10 gives 1 s and 11 gives 2 s. The codes are sampled once, when the debounce window completes. Before their first capture, the held codes stand at 10 (1 s). The power-on request is held back until the sequencer reports that it is idle. Time is measured with a prescaler whose length in clock cycles per millisecond is a parameter. A busy flag covers the whole run, and while it is high new rising edges on the pin are ignored.

Top module: `rebootSequencer`

## Requirements
- R1: While reset is asserted, and after it is released with the pin low, pwrOffReq, pwrOnReq and busy are all 0.
- R2: A run starts only on a rising edge of the synchronised pin. If the pin goes low before 100 ms of debounce have elapsed, the run is abandoned: busy returns to 0 and no request is issued.
- R3: Delay codes map as 00=100 ms, 01=500 ms, 10=1000 ms, 11=2000 ms, with C = CYC_PER_MS cycles per ms. pwrOffReq is high in the cycle after the rising clock edge that comes 4+(100+first)*C edges after the first edge that samples the pin high.
- R4: When seqIdle is already high, pwrOnReq is high exactly second*C+2 clock edges after the edge that raised pwrOffReq.
- R5: pwrOnReq is never issued while seqIdle is low. Once the second delay has elapsed, it rises on the first clock edge that samples seqIdle high.
- R6: Each request is a single-cycle pulse, and the two requests are never high together.
- R7: busy rises when debounce starts and stays high until the edge on which pwrOnReq rises, when it falls.
- R8: A rising edge of the pin is ignored while busy is high. This includes an edge whose detection lands on the same edge that issues pwrOnReq. An edge detected one cycle later starts a new run.
- R9: The delay codes are captured when debounce completes. Changing firstDly or secondDly after that has no effect on the current run's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rebootPin | input | 1 | Raw, asynchronous reboot request pin |
| firstDly | input | 2 | Code for the delay before power-off |
| secondDly | input | 2 | Code for the delay before power-on |
| seqIdle | input | 1 | Power sequencer is idle and can accept power-on |
| pwrOffReq | output | 1 | One-cycle power-off request |
| pwrOnReq | output | 1 | One-cycle power-on request |
| busy | output | 1 | A reboot run is in progress |

## Verification
Two events can meet in one cycle: the power-on request that ends a run, and the detection of a fresh rising edge on the pin. The bench drops the pin during the first delay. It then raises the pin so that the synchronised edge is detected exactly on the power-on edge, and expects no new pulse and busy low for longer than a full debounce and delay. A second case raises the pin one cycle later and expects a complete new run with exactly predicted pulse cycles. This shows the cut-off lies precisely at the end of busy.

// File: rtl/rebootSeqPkg.sv
package rebootSeqPkg;

  localparam int unsigned DLY_MS_LONGEST = 2000;
  localparam logic [1:0]  DLY_CODE_RESET = 2'b10;

  typedef enum logic [1:0] {
    TGT_DEBOUNCE = 2'd0,
    TGT_FIRST    = 2'd1,
    TGT_SECOND   = 2'd2
  } tgtSel_e;

  typedef struct packed {
    logic    clrTimer;
    logic    latchCodes;
    tgtSel_e tgtSel;
  } ctlStrobe_t;

  function automatic int unsigned codeToMs(input logic [1:0] code);
    case (code)
      2'b00:   return 100;
      2'b01:   return 500;
      2'b10:   return 1000;
      default: return DLY_MS_LONGEST;
    endcase
  endfunction

endpackage

// File: rtl/rebootSeqDp.sv
module rebootSeqDp
  import rebootSeqPkg::*;
#(
  parameter int unsigned CYC_PER_MS  = 50000,
  parameter int unsigned DEB_MS      = 100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinRaw,
  input  logic [1:0] firstDly,
  input  logic [1:0] secondDly,
  input  ctlStrobe_t strobe,
  output logic       pinHigh,
  output logic       pinRise,
  output logic       timeUp
);

  localparam int unsigned MS_MAX = (DEB_MS > DLY_MS_LONGEST) ? DEB_MS : DLY_MS_LONGEST;
  localparam int unsigned MS_W   = $clog2(MS_MAX + 1);
  localparam int unsigned PRE_W  = $clog2(CYC_PER_MS + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_MS - 1);
  localparam logic [MS_W-1:0]  MS_SAT   = '1;

  // synchroniser plus one extra stage for edge detection
  logic [SYNC_STAGES:0] syncChain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-1:0], pinRaw};
  end

  assign pinHigh = syncChain[SYNC_STAGES-1];
  assign pinRise = syncChain[SYNC_STAGES-1] & ~syncChain[SYNC_STAGES];

  // captured delay codes
  logic [1:0] firstQ, secondQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstQ  <= DLY_CODE_RESET;
      secondQ <= DLY_CODE_RESET;
    end else if (strobe.latchCodes) begin
      firstQ  <= firstDly;
      secondQ <= secondDly;
    end
  end

  // millisecond prescaler and millisecond counter
  logic [PRE_W-1:0] preCnt;
  logic [MS_W-1:0]  msCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      msCnt  <= '0;
    end else if (strobe.clrTimer) begin
      preCnt <= '0;
      msCnt  <= '0;
    end else if (preCnt == PRE_LAST) begin
      preCnt <= '0;
      if (msCnt != MS_SAT) msCnt <= msCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  logic [MS_W-1:0] msTarget;

  always_comb begin
    case (strobe.tgtSel)
      TGT_DEBOUNCE: msTarget = MS_W'(DEB_MS);
      TGT_FIRST:    msTarget = MS_W'(codeToMs(firstQ));
      default:      msTarget = MS_W'(codeToMs(secondQ));
    endcase
  end

  assign timeUp = (msCnt == msTarget);

endmodule

// File: rtl/rebootSeqCtl.sv
module rebootSeqCtl
  import rebootSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinHigh,
  input  logic       pinRise,
  input  logic       timeUp,
  input  logic       seqIdle,
  output ctlStrobe_t strobe,
  output logic       pwrOffReq,
  output logic       pwrOnReq,
  output logic       busy
);

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DEB     = 3'd1,
    ST_FIRST   = 3'd2,
    ST_SECOND  = 3'd3,
    ST_ONWAIT  = 3'd4
  } state_e;

  state_e state, stateNext;
  logic   offNext, onNext;

  always_comb begin
    stateNext         = state;
    offNext           = 1'b0;
    onNext            = 1'b0;
    strobe.clrTimer   = 1'b0;
    strobe.latchCodes = 1'b0;
    strobe.tgtSel     = TGT_DEBOUNCE;
    case (state)
      ST_IDLE: begin
        strobe.clrTimer = 1'b1;
        if (pinRise) stateNext = ST_DEB;
      end
      ST_DEB: begin
        if (!pinHigh) begin
          stateNext = ST_IDLE;
        end else if (timeUp) begin
          stateNext         = ST_FIRST;
          strobe.clrTimer   = 1'b1;
          strobe.latchCodes = 1'b1;
        end
      end
      ST_FIRST: begin
        strobe.tgtSel = TGT_FIRST;
        if (timeUp) begin
          stateNext       = ST_SECOND;
          strobe.clrTimer = 1'b1;
          offNext         = 1'b1;
        end
      end
      ST_SECOND: begin
        strobe.tgtSel = TGT_SECOND;
        if (timeUp) stateNext = ST_ONWAIT;
      end
      ST_ONWAIT: begin
        strobe.tgtSel = TGT_SECOND;
        if (seqIdle) begin
          stateNext = ST_IDLE;
          onNext    = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pwrOffReq <= 1'b0;
      pwrOnReq  <= 1'b0;
      busy      <= 1'b0;
    end else begin
      state     <= stateNext;
      pwrOffReq <= offNext;
      pwrOnReq  <= onNext;
      busy      <= (stateNext != ST_IDLE);
    end
  end

endmodule

// File: rtl/rebootSequencer.sv
module rebootSequencer
  import rebootSeqPkg::*;
#(
  parameter int unsigned CYC_PER_MS  = 50000,
  parameter int unsigned DEB_MS      = 100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rebootPin,
  input  logic [1:0] firstDly,
  input  logic [1:0] secondDly,
  input  logic       seqIdle,
  output logic       pwrOffReq,
  output logic       pwrOnReq,
  output logic       busy
);

  ctlStrobe_t strobe;
  logic       pinHigh, pinRise, timeUp;

  rebootSeqDp #(
    .CYC_PER_MS (CYC_PER_MS),
    .DEB_MS     (DEB_MS),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .pinRaw   (rebootPin),
    .firstDly (firstDly),
    .secondDly(secondDly),
    .strobe   (strobe),
    .pinHigh  (pinHigh),
    .pinRise  (pinRise),
    .timeUp   (timeUp)
  );

  rebootSeqCtl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .pinHigh  (pinHigh),
    .pinRise  (pinRise),
    .timeUp   (timeUp),
    .seqIdle  (seqIdle),
    .strobe   (strobe),
    .pwrOffReq(pwrOffReq),
    .pwrOnReq (pwrOnReq),
    .busy     (busy)
  );

endmodule

// File: rtl/rebootSequencerChk.sv
module rebootSequencerChk (
  input logic clk,
  input logic rstN,
  input logic seqIdle,
  input logic pwrOffReq,
  input logic pwrOnReq,
  input logic busy
);

  AST_OFF_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    pwrOffReq |=> !pwrOffReq); // R6
  AST_ON_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    pwrOnReq |=> !pwrOnReq); // R6
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(pwrOffReq && pwrOnReq)); // R6
  AST_OFF_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    pwrOffReq |-> busy); // R7
  AST_ON_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    pwrOnReq |-> (!busy && $past(busy))); // R7
  AST_ON_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    pwrOnReq |-> $past(seqIdle)); // R5

  always_comb begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!pwrOffReq && !pwrOnReq && !busy); // R1
    end
  end

endmodule

bind rebootSequencer rebootSequencerChk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .seqIdle  (seqIdle),
  .pwrOffReq(pwrOffReq),
  .pwrOnReq (pwrOnReq),
  .busy     (busy)
);

// File: tb/sim_rebootSequencer.sv
`timescale 1ns/1ps
module sim_rebootSequencer;

  localparam int C      = 2;   // cycles per ms in this bench
  localparam int DEB    = 100;
  localparam int KIND_OFF = 0;
  localparam int KIND_ON  = 1;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rebootPin = 1'b0;
  logic [1:0] firstDly = 2'b00;
  logic [1:0] secondDly = 2'b00;
  logic       seqIdle = 1'b1;
  logic       pwrOffReq, pwrOnReq, busy;

  int cyc = 0;
  int checkCnt = 0;
  int failCnt = 0;
  bit doneFlag = 1'b0;

  typedef struct {
    int    kind;
    int    when;
    string req;
  } expItem_t;

  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  rebootSequencer #(.CYC_PER_MS(C), .DEB_MS(DEB)) u0 (
    .clk(clk), .rstN(rstN), .rebootPin(rebootPin),
    .firstDly(firstDly), .secondDly(secondDly), .seqIdle(seqIdle),
    .pwrOffReq(pwrOffReq), .pwrOnReq(pwrOnReq), .busy(busy)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int msOf(input logic [1:0] code);
    case (code)
      2'b00:   return 100;
      2'b01:   return 500;
      2'b10:   return 1000;
      default: return 2000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic pushExp(input int kind, input int when, input string req);
    expItem_t it;
    it.kind = kind; it.when = when; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic waitUntil(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  // monitor: pops expected pulses and compares kind and cycle
  logic prevOff = 1'b0, prevOn = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevOff) chk(!pwrOffReq, "R6 off pulse width", int'(pwrOffReq), 0);
      if (prevOn)  chk(!pwrOnReq,  "R6 on pulse width",  int'(pwrOnReq), 0);
      if ((pwrOffReq && !prevOff) || (pwrOnReq && !prevOn)) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R8 unexpected request", int'({pwrOnReq, pwrOffReq}), 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          chk(((it.kind == KIND_ON) ? pwrOnReq : pwrOffReq) && !(pwrOnReq && pwrOffReq),
              {it.req, " kind"}, int'({pwrOnReq, pwrOffReq}), (it.kind == KIND_ON) ? 2 : 1);
          chk(cyc == it.when, {it.req, " cycle"}, cyc, it.when);
        end
      end
    end
    prevOff <= pwrOffReq;
    prevOn  <= pwrOnReq;
  end

  // mode 0: plain; 1: poke codes and pin in first delay (R9, R8);
  // 2: re-raise pin so detection meets the power-on edge (R8 ignored);
  // 3: re-raise one cycle later (R8 accepted, chained run)
  task automatic runSeq(input logic [1:0] d1, input logic [1:0] d2, input int mode);
    int p0, offC, onC, off2, on2;
    @(negedge clk);
    rebootPin = 1'b1; firstDly = d1; secondDly = d2;
    p0   = cyc;
    offC = p0 + 5 + (DEB + msOf(d1)) * C;
    onC  = offC + msOf(d2) * C + 2;
    pushExp(KIND_OFF, offC, "R3 power-off timing");
    pushExp(KIND_ON,  onC,  "R4 power-on timing");
    waitUntil(p0 + 10);
    chk(busy, "R7 busy in debounce", int'(busy), 1);
    if (mode == 1) begin
      waitUntil(p0 + 10 + DEB * C);
      firstDly = ~d1; secondDly = ~d2; rebootPin = 1'b0;
      repeat (6) @(negedge clk);
      rebootPin = 1'b1;
    end
    if (mode >= 2) begin
      waitUntil(offC - 20);
      rebootPin = 1'b0;
    end
    waitUntil(offC + 3);
    chk(busy, "R7 busy after power-off", int'(busy), 1);
    if (mode == 2) begin
      waitUntil(onC - 3);
      rebootPin = 1'b1;
      waitUntil(onC + (DEB + 2 * msOf(d1)) * C + 50);
      chk(!busy, "R8 edge on power-on cycle ignored", int'(busy), 0);
      chk(expQ.size() == 0, "R8 no extra request", expQ.size(), 0);
    end else if (mode == 3) begin
      waitUntil(onC - 2);
      rebootPin = 1'b1;
      off2 = (onC - 2) + 5 + (DEB + msOf(firstDly)) * C;
      on2  = off2 + msOf(secondDly) * C + 2;
      pushExp(KIND_OFF, off2, "R8 edge after busy accepted off");
      pushExp(KIND_ON,  on2,  "R8 edge after busy accepted on");
      waitUntil(onC + 5);
      chk(busy, "R8 new run busy", int'(busy), 1);
      waitUntil(on2 + 1);
    end else begin
      waitUntil(onC + 1);
    end
    chk(!busy, "R7 busy cleared after power-on", int'(busy), 0);
    chk(expQ.size() == 0, "R4 all requests seen", expQ.size(), 0);
    rebootPin = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin : mainFlow
    int p0, offC, q;
    repeat (3) @(negedge clk);
    chk(!pwrOffReq && !pwrOnReq && !busy, "R1 outputs in reset",
        int'({busy, pwrOnReq, pwrOffReq}), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk(!pwrOffReq && !pwrOnReq && !busy, "R1 outputs after reset",
        int'({busy, pwrOnReq, pwrOffReq}), 0);

    runSeq(2'b00, 2'b00, 0);   // R3 R4
    runSeq(2'b01, 2'b11, 0);
    runSeq(2'b11, 2'b10, 0);
    runSeq(2'b10, 2'b01, 0);

    // R2: pin drops halfway through debounce
    @(negedge clk);
    rebootPin = 1'b1; firstDly = 2'b00; secondDly = 2'b00;
    p0 = cyc;
    waitUntil(p0 + 50 * C);
    chk(busy, "R2 busy during debounce", int'(busy), 1);
    rebootPin = 1'b0;
    waitUntil(p0 + 50 * C + 6);
    chk(!busy, "R2 abort returns to idle", int'(busy), 0);
    waitUntil(p0 + (DEB + 200) * C);
    chk(expQ.size() == 0 && !busy, "R2 no request after abort", int'(busy), 0);

    runSeq(2'b00, 2'b00, 1);   // R9 and R8 edge during first delay

    // R5: sequencer not idle holds power-on
    seqIdle = 1'b0;
    @(negedge clk);
    rebootPin = 1'b1; firstDly = 2'b00; secondDly = 2'b00;
    p0   = cyc;
    offC = p0 + 5 + (DEB + 100) * C;
    pushExp(KIND_OFF, offC, "R5 power-off before hold");
    waitUntil(offC + 100 * C + 40);
    chk(busy, "R5 busy while held", int'(busy), 1);
    chk(expQ.size() == 0, "R5 no power-on while not idle", expQ.size(), 0);
    seqIdle = 1'b1;
    q = cyc;
    pushExp(KIND_ON, q + 1, "R5 power-on after idle");
    waitUntil(q + 3);
    chk(!busy, "R5 busy cleared", int'(busy), 0);
    rebootPin = 1'b0;
    repeat (5) @(negedge clk);

    runSeq(2'b00, 2'b00, 2);   // R8 coincident edge ignored
    runSeq(2'b00, 2'b00, 3);   // R8 edge one cycle later accepted

    doneFlag = 1'b1;
  end

  initial begin : finishCtl
    fork
      wait (doneFlag);
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R1 watchdog expired", cyc, 0);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule